// File: doc/BRIEF.md
# RAM Controller Interrupt and Status Register Block

This block is the software-facing register file of an on-chip RAM controller. It sits on a simple 32-bit word bus and collects eleven error event lines from the controller into a sticky status register. It keeps a per-source mask and drives one level-sensitive interrupt line. Software never writes the mask directly. It unmasks sources by writing ones to an enable register and masks them by writing ones to a disable register. Status bits are cleared by writing a one to them.

The block also holds a small error-control register and an implementation register that reports the configured RAM size as a code. It has a ready-debug register with a fixed value, and two pairs of read-only capture registers. Each pair latches a first-failing address and a syndrome when the controller strobes a correctable or an uncorrectable error. The RAM size is a parameter, and a value outside the five supported sizes stops elaboration.

Top module: `ramc_irq_regs`

## Requirements
- R1: After reset the status register reads 0x000, the mask reads 0x7FF, error-control reads 0xF, and irq_o is low.
- R2: A high err_evt_i bit sets the matching status bit on the next clock edge. When a status write with a one in that bit arrives in the same cycle, the event wins and the bit stays set.
- R3: A write to the status register (byte offset 0x04, bits [10:0]) clears each bit where the write data is 1 and leaves bits written with 0 unchanged. Bits [31:11] read as zero.
- R4: A write to the mask register (offset 0x08) has no effect. A write to the enable register (0x0C) clears the mask bits where the data is 1. A write to the disable register (0x10) sets the mask bits where the data is 1. Enable and disable always read as zero.
- R5: irq_o is high exactly when some status bit is 1 while its mask bit is 0.
- R6: The error-control register (offset 0x00) stores write data bits [3:0]. Bits [31:4] read as zero.
- R7: The implementation register (offset 0x14) reads the size code in bits [3:0]: 64 KiB=0, 128 KiB=1, 256 KiB=2, 512 KiB=3, 1 MiB=4. Writes do not change it. The default size is 1 MiB. Any other size is an elaboration error.
- R8: A pulse on ce_cap_i or ue_cap_i loads the 20-bit address and 16-bit syndrome inputs. They read at offsets 0x20/0x24 for correctable errors and 0x28/0x2C for uncorrectable errors, with upper bits zero. Bus writes to them have no effect.
- R9: The ready-debug register (offset 0x18) reads 0x0000FFFF and ignores writes.
- R10: An access whose address bits [1:0] are not zero writes nothing and reads zero. A read of an unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel_i | input | 1 | Bus access in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, same cycle as the read, zero when not reading |
| err_evt_i | input | 11 | Per-source error event pulses |
| ce_cap_i | input | 1 | Capture strobe for correctable error info |
| ce_addr_i | input | 20 | Correctable first-failing address |
| ce_syn_i | input | 16 | Correctable syndrome |
| ue_cap_i | input | 1 | Capture strobe for uncorrectable error info |
| ue_addr_i | input | 20 | Uncorrectable first-failing address |
| ue_syn_i | input | 16 | Uncorrectable syndrome |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds two copies of the block. The first uses the default 1 MiB size and an 8-bit address, and it carries all register, mask and interrupt traffic. The second is built for 64 KiB and shares the same bus, so the implementation code can be checked at both ends of the supported range. The 8-bit address reaches the offsets just above the mapped ones and the last word of the space, which covers the unmapped-read rule. The 1 MiB instance also covers the case where an event and a clearing write hit the same status bit in one cycle, and a reset asserted in the middle of the run.

// File: rtl/ramc_regs_pkg.sv
package ramc_regs_pkg;

  localparam int unsigned BUS_W  = 32;
  localparam int unsigned SRC_N  = 11;
  localparam int unsigned CTL_W  = 4;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned FFA_W  = 20;
  localparam int unsigned SYN_W  = 16;
  localparam int unsigned RDY_W  = 16;
  localparam int unsigned IDX_W  = 6;   // word index width of the mapped window

  localparam logic [CTL_W-1:0] CTL_RST   = '1;
  localparam logic [RDY_W-1:0] RDY_VALUE = '1;

  // word indices (byte offset / 4)
  localparam logic [IDX_W-1:0] IX_CTL  = 6'd0;
  localparam logic [IDX_W-1:0] IX_STS  = 6'd1;
  localparam logic [IDX_W-1:0] IX_MSK  = 6'd2;
  localparam logic [IDX_W-1:0] IX_ENA  = 6'd3;
  localparam logic [IDX_W-1:0] IX_DIS  = 6'd4;
  localparam logic [IDX_W-1:0] IX_IMPL = 6'd5;
  localparam logic [IDX_W-1:0] IX_RDY  = 6'd6;
  localparam logic [IDX_W-1:0] IX_CEA  = 6'd8;
  localparam logic [IDX_W-1:0] IX_CES  = 6'd9;
  localparam logic [IDX_W-1:0] IX_UEA  = 6'd10;
  localparam logic [IDX_W-1:0] IX_UES  = 6'd11;

  typedef struct packed {
    logic ctl;
    logic sts;
    logic msk;
    logic ena;
    logic dis;
  } wstb_t;

  function automatic int size_to_code(input longint unsigned nbytes);
    case (nbytes)
      64'd65536:   return 0;
      64'd131072:  return 1;
      64'd262144:  return 2;
      64'd524288:  return 3;
      64'd1048576: return 4;
      default:     return -1;
    endcase
  endfunction

endpackage

// File: rtl/ramc_bus_decode.sv
module ramc_bus_decode
  import ramc_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wstb_t             wstb_o,
  output logic              rd_o,
  output logic [IDX_W-1:0]  idx_o
);

  localparam int unsigned OFF_W = ADDR_W - 2;

  logic [OFF_W-1:0] word_idx;
  logic             aligned;
  logic             in_win;
  logic             acc_ok;
  logic             wr_ok;

  always_comb begin
    word_idx = addr_i[ADDR_W-1:2];
    aligned  = (addr_i[1:0] == 2'b00);
    in_win   = ((word_idx >> IDX_W) == '0);
    acc_ok   = sel_i & aligned & in_win;
    wr_ok    = acc_ok & wr_i;
    rd_o     = acc_ok & ~wr_i;
    idx_o    = word_idx[IDX_W-1:0];

    wstb_o.ctl = wr_ok && (idx_o == IX_CTL);
    wstb_o.sts = wr_ok && (idx_o == IX_STS);
    wstb_o.msk = wr_ok && (idx_o == IX_MSK);
    wstb_o.ena = wr_ok && (idx_o == IX_ENA);
    wstb_o.dis = wr_ok && (idx_o == IX_DIS);
  end

  // R10
  always_comb begin
    if (sel_i && (addr_i[1:0] != 2'b00)) begin
      misalign_quiet_chk: assert ((wstb_o == '0) && !rd_o)
        else $error("misaligned access produced a strobe");
    end
  end

endmodule

// File: rtl/ramc_irq_core.sv
module ramc_irq_core #(
  parameter int unsigned SRC_N = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] evt_i,
  input  logic             sts_we_i,
  input  logic             msk_we_i,
  input  logic             ena_we_i,
  input  logic             dis_we_i,
  input  logic [SRC_N-1:0] wdata_i,
  output logic [SRC_N-1:0] sts_o,
  output logic [SRC_N-1:0] msk_o,
  output logic             irq_o
);

  logic [SRC_N-1:0] sts_q, sts_d;
  logic [SRC_N-1:0] msk_q, msk_d;
  logic             sts_en, msk_en;

  always_comb begin
    sts_en = sts_we_i | (|evt_i);
    sts_d  = sts_q;
    if (sts_we_i) sts_d = sts_d & ~wdata_i;
    sts_d  = sts_d | evt_i;   // a new event beats a same-cycle clear

    msk_en = ena_we_i | dis_we_i;
    msk_d  = msk_q;
    if (ena_we_i) msk_d = msk_d & ~wdata_i;
    if (dis_we_i) msk_d = msk_d | wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      msk_q <= '1;
    end else begin
      if (sts_en) sts_q <= sts_d;
      if (msk_en) msk_q <= msk_d;
    end
  end

  assign sts_o = sts_q;
  assign msk_o = msk_q;
  assign irq_o = |(sts_q & ~msk_q);

  // R2
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((sts_q & $past(evt_i)) == $past(evt_i)));

  // R3
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_we_i && (evt_i == '0)) |=> ((sts_q & $past(wdata_i)) == '0));

  // R4
  mask_direct_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_we_i) |=> $stable(msk_q));

  // R4
  enable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_we_i) |=> ((msk_q & $past(wdata_i)) == '0));

  // R4
  disable_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_we_i) |=> ((msk_q & $past(wdata_i)) == $past(wdata_i)));

  // R5
  full_mask_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_q == '1) |-> !irq_o);

endmodule

// File: rtl/ramc_err_capture.sv
module ramc_err_capture #(
  parameter int unsigned AW = 20,
  parameter int unsigned SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_i,
  input  logic [AW-1:0] addr_i,
  input  logic [SW-1:0] syn_i,
  output logic [AW-1:0] addr_o,
  output logic [SW-1:0] syn_o
);

  logic [AW-1:0] addr_q, addr_d;
  logic [SW-1:0] syn_q, syn_d;

  always_comb begin
    addr_d = addr_i;
    syn_d  = syn_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      syn_q  <= '0;
    end else if (cap_i) begin
      addr_q <= addr_d;
      syn_q  <= syn_d;
    end
  end

  assign addr_o = addr_q;
  assign syn_o  = syn_q;

  // R8
  cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> ((addr_o == $past(addr_i)) && (syn_o == $past(syn_i))));

  // R8
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> ($stable(addr_o) && $stable(syn_o)));

endmodule

// File: rtl/ramc_irq_regs.sv
module ramc_irq_regs
  import ramc_regs_pkg::*;
#(
  parameter longint unsigned RAM_BYTES = 64'd1048576,
  parameter int unsigned     ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [10:0]       err_evt_i,
  input  logic              ce_cap_i,
  input  logic [19:0]       ce_addr_i,
  input  logic [15:0]       ce_syn_i,
  input  logic              ue_cap_i,
  input  logic [19:0]       ue_addr_i,
  input  logic [15:0]       ue_syn_i,
  output logic              irq_o
);

  localparam int               SIZE_CODE = size_to_code(RAM_BYTES);
  localparam logic [CODE_W-1:0] IMPL_VAL = (SIZE_CODE < 0) ? '0 : CODE_W'(SIZE_CODE);
  localparam int unsigned      CAP_N     = 2;

  generate
    if (SIZE_CODE < 0) begin : g_bad_size
      $error("ramc_irq_regs: RAM_BYTES must be 64K, 128K, 256K, 512K or 1M");
    end
    if (ADDR_W < IDX_W + 2) begin : g_bad_addr
      $error("ramc_irq_regs: ADDR_W too small for the register window");
    end
  endgenerate

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  // decode
  wstb_t            wstb;
  logic             rd;
  logic [IDX_W-1:0] idx;

  ramc_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel_i  (bus_sel_i),
    .wr_i   (bus_wr_i),
    .addr_i (bus_addr_i),
    .wstb_o (wstb),
    .rd_o   (rd),
    .idx_o  (idx)
  );

  // error-control register
  logic [CTL_W-1:0] ctl_q, ctl_d;

  always_comb begin
    ctl_d = bus_wdata_i[CTL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  ctl_q <= CTL_RST;
    else if (wstb.ctl) ctl_q <= ctl_d;
  end

  // interrupt status and mask
  logic [SRC_N-1:0] sts, msk;

  ramc_irq_core #(.SRC_N(SRC_N)) u_irq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .evt_i    (err_evt_i),
    .sts_we_i (wstb.sts),
    .msk_we_i (wstb.msk),
    .ena_we_i (wstb.ena),
    .dis_we_i (wstb.dis),
    .wdata_i  (bus_wdata_i[SRC_N-1:0]),
    .sts_o    (sts),
    .msk_o    (msk),
    .irq_o    (irq_o)
  );

  // capture pairs: index 0 correctable, 1 uncorrectable
  logic [CAP_N-1:0]            cap_stb;
  logic [CAP_N-1:0][FFA_W-1:0] cap_a_in, cap_a;
  logic [CAP_N-1:0][SYN_W-1:0] cap_s_in, cap_s;

  assign cap_stb  = {ue_cap_i, ce_cap_i};
  assign cap_a_in = {ue_addr_i, ce_addr_i};
  assign cap_s_in = {ue_syn_i, ce_syn_i};

  genvar k;
  generate
    for (k = 0; k < CAP_N; k++) begin : g_cap
      ramc_err_capture #(.AW(FFA_W), .SW(SYN_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .cap_i  (cap_stb[k]),
        .addr_i (cap_a_in[k]),
        .syn_i  (cap_s_in[k]),
        .addr_o (cap_a[k]),
        .syn_o  (cap_s[k])
      );
    end
  endgenerate

  // read mux
  logic [BUS_W-1:0] rdata_d;

  always_comb begin
    rdata_d = '0;
    if (rd) begin
      case (idx)
        IX_CTL:  rdata_d[CTL_W-1:0]  = ctl_q;
        IX_STS:  rdata_d[SRC_N-1:0]  = sts;
        IX_MSK:  rdata_d[SRC_N-1:0]  = msk;
        IX_IMPL: rdata_d[CODE_W-1:0] = IMPL_VAL;
        IX_RDY:  rdata_d[RDY_W-1:0]  = RDY_VALUE;
        IX_CEA:  rdata_d[FFA_W-1:0]  = cap_a[0];
        IX_CES:  rdata_d[SYN_W-1:0]  = cap_s[0];
        IX_UEA:  rdata_d[FFA_W-1:0]  = cap_a[1];
        IX_UES:  rdata_d[SYN_W-1:0]  = cap_s[1];
        default: rdata_d = '0;
      endcase
    end
  end

  assign bus_rdata_o = rdata_d;

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^bus_wdata_i[BUS_W-1:SRC_N];

  // R6
  ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wstb.ctl |=> (ctl_q == $past(bus_wdata_i[CTL_W-1:0])));

endmodule

// File: tb/sim_ramc_irq_regs.sv
`timescale 1ns/100ps
module sim_ramc_irq_regs;

  logic        clk;
  logic        rst_n;
  logic        sel, wr;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata, rdata1;
  logic [10:0] evt;
  logic        ce_cap, ue_cap;
  logic [19:0] ce_a, ue_a;
  logic [15:0] ce_s, ue_s;
  logic        irq, irq1;

  int n_chk;
  int n_fail;

  ramc_irq_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .err_evt_i(evt),
    .ce_cap_i(ce_cap), .ce_addr_i(ce_a), .ce_syn_i(ce_s),
    .ue_cap_i(ue_cap), .ue_addr_i(ue_a), .ue_syn_i(ue_s), .irq_o(irq)
  );

  ramc_irq_regs #(.RAM_BYTES(64'd65536)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata1), .err_evt_i(evt),
    .ce_cap_i(ce_cap), .ce_addr_i(ce_a), .ce_syn_i(ce_s),
    .ue_cap_i(ue_cap), .ue_addr_i(ue_a), .ue_syn_i(ue_s), .irq_o(irq1)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  localparam logic [1:0] OP_WR = 2'd0;
  localparam logic [1:0] OP_RD = 2'd1;
  localparam logic [1:0] OP_EV = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic        irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VEC [NV] = '{
    '{OP_RD, 8'h00, 32'h0000000F, 1'b0, 4'd1},   // R1 ctl reset
    '{OP_RD, 8'h04, 32'h00000000, 1'b0, 4'd1},   // R1 status reset
    '{OP_RD, 8'h08, 32'h000007FF, 1'b0, 4'd1},   // R1 mask reset
    '{OP_RD, 8'h18, 32'h0000FFFF, 1'b0, 4'd9},   // R9
    '{OP_RD, 8'h14, 32'h00000004, 1'b0, 4'd7},   // R7 1 MiB
    '{OP_EV, 8'h00, 32'h00000005, 1'b0, 4'd2},   // R2
    '{OP_RD, 8'h04, 32'h00000005, 1'b0, 4'd2},   // R2 masked, no irq
    '{OP_WR, 8'h0C, 32'h00000001, 1'b0, 4'd4},   // R4 enable bit0
    '{OP_RD, 8'h08, 32'h000007FE, 1'b1, 4'd5},   // R5
    '{OP_RD, 8'h0C, 32'h00000000, 1'b1, 4'd4},   // R4 enable reads 0
    '{OP_WR, 8'h08, 32'h00000000, 1'b0, 4'd4},   // R4 direct mask write
    '{OP_RD, 8'h08, 32'h000007FE, 1'b1, 4'd4},
    '{OP_WR, 8'h04, 32'h00000001, 1'b0, 4'd3},   // R3 clear bit0
    '{OP_RD, 8'h04, 32'h00000004, 1'b0, 4'd5},   // R5 irq drops
    '{OP_WR, 8'h04, 32'h00000000, 1'b0, 4'd3},   // R3 zero write
    '{OP_RD, 8'h04, 32'h00000004, 1'b0, 4'd3},
    '{OP_WR, 8'h10, 32'h00000001, 1'b0, 4'd4},   // R4 disable bit0
    '{OP_RD, 8'h08, 32'h000007FF, 1'b0, 4'd4},
    '{OP_WR, 8'h0C, 32'h00000004, 1'b0, 4'd4},   // R4 enable bit2
    '{OP_RD, 8'h08, 32'h000007FB, 1'b1, 4'd5},   // R5
    '{OP_RD, 8'h10, 32'h00000000, 1'b1, 4'd4},   // R4 disable reads 0
    '{OP_WR, 8'h00, 32'hFFFFFFF5, 1'b0, 4'd6},   // R6
    '{OP_RD, 8'h00, 32'h00000005, 1'b1, 4'd6},
    '{OP_WR, 8'h14, 32'h00000000, 1'b0, 4'd7},   // R7 read-only
    '{OP_RD, 8'h14, 32'h00000004, 1'b1, 4'd7},
    '{OP_WR, 8'h18, 32'h00000000, 1'b0, 4'd9},   // R9 read-only
    '{OP_RD, 8'h18, 32'h0000FFFF, 1'b1, 4'd9},
    '{OP_WR, 8'h04, 32'hFFFFFFFF, 1'b0, 4'd3},   // R3 clear all
    '{OP_RD, 8'h04, 32'h00000000, 1'b0, 4'd3},
    '{OP_WR, 8'h01, 32'h00000000, 1'b0, 4'd10},  // R10 misaligned write
    '{OP_RD, 8'h00, 32'h00000005, 1'b0, 4'd10},
    '{OP_RD, 8'h01, 32'h00000000, 1'b0, 4'd10},  // R10 misaligned read
    '{OP_RD, 8'h1C, 32'h00000000, 1'b0, 4'd10},  // R10 unmapped
    '{OP_RD, 8'hFC, 32'h00000000, 1'b0, 4'd10},
    '{OP_WR, 8'h10, 32'hFFFFFFFF, 1'b0, 4'd4},   // R4 mask all
    '{OP_RD, 8'h08, 32'h000007FF, 1'b0, 4'd4}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input string tag, input logic [7:0] a,
                          input logic [31:0] exp, input logic exp_irq);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1;
    check(tag, rdata, exp);
    check({tag, " irq"}, {31'd0, irq}, {31'd0, exp_irq});
    sel = 1'b0;
  endtask

  task automatic pulse_evt(input logic [10:0] e);
    @(negedge clk);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic finish_run;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0; evt = '0;
    ce_cap = 1'b0; ue_cap = 1'b0; ce_a = '0; ue_a = '0; ce_s = '0; ue_s = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      case (VEC[i].op)
        OP_WR:   bus_write(VEC[i].addr, VEC[i].data);
        OP_EV:   pulse_evt(VEC[i].data[10:0]);
        default: bus_read(tag, VEC[i].addr, VEC[i].data, VEC[i].irq);
      endcase
    end

    // R2: event and clearing write on the same bit in one cycle
    @(negedge clk);
    evt = 11'h008; sel = 1'b1; wr = 1'b1; addr = 8'h04; wdata = 32'h8;
    @(negedge clk);
    evt = '0; sel = 1'b0; wr = 1'b0;
    bus_read("R2 set beats clear", 8'h04, 32'h8, 1'b0);

    // R5: unmasking a pending bit raises irq
    bus_write(8'h0C, 32'h8);
    bus_read("R5 unmask pending", 8'h08, 32'h7F7, 1'b1);

    // R8: capture registers
    @(negedge clk);
    ce_cap = 1'b1; ce_a = 20'hABCDE; ce_s = 16'h1234;
    ue_cap = 1'b1; ue_a = 20'h0F00D; ue_s = 16'hBEEF;
    @(negedge clk);
    ce_cap = 1'b0; ue_cap = 1'b0; ce_a = 20'h11111; ue_a = 20'h22222;
    bus_read("R8 ce addr", 8'h20, 32'h000ABCDE, 1'b1);
    bus_read("R8 ce syn", 8'h24, 32'h00001234, 1'b1);
    bus_read("R8 ue addr", 8'h28, 32'h0000F00D, 1'b1);
    bus_read("R8 ue syn", 8'h2C, 32'h0000BEEF, 1'b1);
    bus_write(8'h20, 32'hFFFFFFFF);
    bus_write(8'h2C, 32'h0);
    bus_read("R8 ce addr write ignored", 8'h20, 32'h000ABCDE, 1'b1);
    bus_read("R8 ue syn write ignored", 8'h2C, 32'h0000BEEF, 1'b1);

    // R7: 64 KiB instance
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = 8'h14;
    #1;
    check("R7 64KiB code", rdata1, 32'h0);
    sel = 1'b0;

    // R1: reset in mid-run restores defaults
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 irq in reset", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_read("R1 status after reset", 8'h04, 32'h0, 1'b0);
    bus_read("R1 mask after reset", 8'h08, 32'h7FF, 1'b0);
    bus_read("R1 ctl after reset", 8'h00, 32'hF, 1'b0);

    finish_run();
  end

endmodule